// File: doc/BRIEF.md
# Free-Running Timer with Shared Prescaler

An 8-bit up-counting timer that advances either on an internal instruction-rate tick or on edges seen at an external input pin. The counter wraps from its maximum back to zero. Each wrap raises a sticky overflow flag, which stays up until a clear strobe takes it down. A software write strobe loads the count. For two cycles after a load the counter does not advance, so a value just written is not consumed at once.

A single power-of-two prescaler sits between a source and its consumer, and it is shared. A control bit gives it either to the timer or to an external watchdog. The side that does not hold the prescaler receives its ticks undivided. The external pin is brought into the clock domain through a synchronizer chain. Its counting edge, rising or falling, is chosen by a control bit. While the sleep input is high, the timer source is gated off.

Top module: `freerun_timer`

## Requirements
- R1: With the timer source active, the count advances by exactly one per accepted timer tick and wraps from 255 to 0. With the internal source (ctrl_i[5]=0), a cycle with inst_tick_i low does not advance the count.
- R2: A wrap from 255 to 0 sets ovf_o. ovf_o stays high until flag_clr_i is sampled high. If a wrap and flag_clr_i fall in the same cycle, the flag ends set.
- R3: When wr_en_i is high, cnt_o takes wr_data_i at that clock edge. The following two clock edges produce no increment, and the third edge may increment.
- R4: A write takes priority over an increment in the same cycle, and a wrap in that cycle does not set ovf_o.
- R5: With ctrl_i[5]=1 the timer counts external edges only, and inst_tick_i has no effect.
- R6: ctrl_i[4]=0 counts rising edges of ext_clk_i and ctrl_i[4]=1 counts falling edges. A level change that settles between clock edges raises cnt_o at the third rising clock edge after it. The edge of the opposite polarity is not counted.
- R7: With ctrl_i[3]=0 the timer advances once per 2^(ctrl_i[2:0]+1) source ticks, giving ratios from 2 to 256.
- R8: With ctrl_i[3]=1 the timer counts every source tick, and wdt_tick_o pulses (combinationally, with wdt_osc_i) on every 2^(ctrl_i[2:0]+1)-th wdt_osc_i pulse. With ctrl_i[3]=0, wdt_tick_o follows wdt_osc_i.
- R9: With ctrl_i[3]=0 a timer write clears the prescaler and wdt_clr_i does not. With ctrl_i[3]=1, wdt_clr_i clears the prescaler.
- R10: While sleep_i is high, cnt_o does not advance.
- R11: After reset cnt_o is 0, ovf_o is 0 and the prescaler is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 6 | [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio select |
| inst_tick_i | input | 1 | Internal instruction-rate tick enable |
| ext_clk_i | input | 1 | Asynchronous external count input |
| sleep_i | input | 1 | Sleep mode, gates the timer source |
| wr_en_i | input | 1 | Count register write strobe |
| wr_data_i | input | 8 | Count value to load |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| wdt_osc_i | input | 1 | Watchdog base tick |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| cnt_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| wdt_tick_o | output | 1 | Tick delivered to the watchdog |

## Verification
The counter is driven by a tick on every cycle and also by gapped ticks. The gapped pattern separates advancing on each accepted tick from advancing on each clock. Loads placed just below the wrap point, and loads in the very cycle of the wrap, separate the two-cycle freeze, write-over-increment priority and set-over-clear priority. The prescaler is run at ratios 4 and 256, and it is reloaded partway through a period. This shows whether the ratio follows the selector and which strobe empties the prescaler for each owner. External levels toggled under both polarities show edge selection and the synchronizer delay.

// File: rtl/freerun_timer_pkg.sv
package freerun_timer_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned PS_SEL_W = 3;
  localparam int unsigned CTRL_W   = PS_SEL_W + 3;

  typedef struct packed {
    logic                src_ext;
    logic                edge_fall;
    logic                psa_wdt;
    logic [PS_SEL_W-1:0] ps_sel;
  } tmr_ctrl_t;
endpackage

// File: rtl/ext_edge_det.sv
module ext_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= ext_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] & prev_q;

  // R6: an edge is reported for exactly one cycle per level change
  p_edge_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_edge_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/presc_div.sv
module presc_div #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [PSC_W:0] ONE = (PSC_W+1)'(1);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W:0]   ratio;
  logic [PSC_W-1:0] mask;

  // ratio = 2^(sel+1); mask = ratio-1 (modulo 2^PSC_W)
  assign ratio  = ONE << (int'(sel_i) + 1);
  assign mask   = ratio[PSC_W-1:0] - PSC_W'(1);
  assign tick_o = src_i & ((psc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (clr_i)  psc_q <= '0;
    else if (src_i)  psc_q <= psc_q + PSC_W'(1);
  end

  p_psc_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (psc_q == '0));
  p_psc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !src_i) |=> $stable(psc_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int unsigned     HOLD_W  = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              ovf_q;
  logic              adv;
  logic              wrap;

  assign adv  = tick_i & (hold_q == '0) & ~wr_i;
  assign wrap = adv & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (wr_i) begin
      cnt_q  <= wr_data_i;
      hold_q <= HOLD_W'(HOLD_CYC);
    end else begin
      if (hold_q != '0) hold_q <= hold_q - HOLD_W'(1);
      if (adv)          cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ovf_q <= 1'b0;
    else if (wrap)       ovf_q <= 1'b1;
    else if (flag_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && hold_q == '0 && cnt_q == CNT_MAX) |=> (cnt_q == '0 && ovf_q));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  p_flag_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flag_clr_i) |=> ovf_q);
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wr_data_i)));
  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0 && !wr_i) |=> $stable(cnt_q));
  p_no_flag_on_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ovf_q) |=> !ovf_q);
endmodule

// File: rtl/freerun_timer.sv
module freerun_timer
  import freerun_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              inst_tick_i,
  input  logic              ext_clk_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              flag_clr_i,
  input  logic              wdt_osc_i,
  input  logic              wdt_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              wdt_tick_o
);
  tmr_ctrl_t ctrl;
  logic ext_rise, ext_fall;
  logic src_raw, tmr_src;
  logic psc_src, psc_clr, psc_tick;
  logic timer_tick;

  assign ctrl = tmr_ctrl_t'(ctrl_i);

  ext_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clk_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  assign src_raw = ctrl.src_ext ? (ctrl.edge_fall ? ext_fall : ext_rise) : inst_tick_i;
  assign tmr_src = src_raw & ~sleep_i;

  // prescaler follows its owner: source, clear strobe and output
  assign psc_src    = ctrl.psa_wdt ? wdt_osc_i : tmr_src;
  assign psc_clr    = ctrl.psa_wdt ? wdt_clr_i : wr_en_i;
  assign timer_tick = ctrl.psa_wdt ? tmr_src   : psc_tick;
  assign wdt_tick_o = ctrl.psa_wdt ? psc_tick  : wdt_osc_i;

  presc_div #(.PSC_W(CNT_W), .SEL_W(PS_SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psc_clr),
    .src_i  (psc_src),
    .sel_i  (ctrl.ps_sel),
    .tick_o (psc_tick)
  );

  tmr_count #(.CNT_W(CNT_W), .HOLD_CYC(2)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (timer_tick),
    .wr_i       (wr_en_i),
    .wr_data_i  (wr_data_i),
    .flag_clr_i (flag_clr_i),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf_o)
  );

  p_sleep_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !wr_en_i) |=> $stable(cnt_o));
  p_ext_ignores_inst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.src_ext && !ext_rise && !ext_fall && !wr_en_i) |=> $stable(cnt_o));
  p_wdt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_osc_i |-> !wdt_tick_o);
endmodule

// File: tb/freerun_timer_tb_top.sv
module freerun_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] ctrl_i = 6'b001000;
  logic       inst_tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       flag_clr_i = 1'b0;
  logic       wdt_osc_i = 1'b0;
  logic       wdt_clr_i = 1'b0;
  logic [7:0] cnt_o;
  logic       ovf_o;
  logic       wdt_tick_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  freerun_timer dut_i (
    .clk_i, .rst_ni, .ctrl_i, .inst_tick_i, .ext_clk_i, .sleep_i,
    .wr_en_i, .wr_data_i, .flag_clr_i, .wdt_osc_i, .wdt_clr_i,
    .cnt_o, .ovf_o, .wdt_tick_o
  );

  task automatic chk(string req, int got, int exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic load(logic [7:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    cyc(1);
    wr_en_i = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic t_reset;
    chk("R11 cnt", cnt_o, 0);
    chk("R11 ovf", ovf_o, 0);
    chk("R11 wdt_tick", wdt_tick_o, 0);
  endtask

  task automatic t_wrap_flag;
    ctrl_i = 6'b001000; inst_tick_i = 1'b1;
    load(250);  chk("R3 load", cnt_o, 250);
    cyc(1);     chk("R3 frozen1", cnt_o, 250);
    cyc(1);     chk("R3 frozen2", cnt_o, 250);
    cyc(1);     chk("R1 first step", cnt_o, 251);
    cyc(4);     chk("R1 at max", cnt_o, 255); chk("R2 no flag yet", ovf_o, 0);
    cyc(1);     chk("R1 wrap", cnt_o, 0);     chk("R2 flag set", ovf_o, 1);
    cyc(3);     chk("R2 flag held", ovf_o, 1); chk("R1 after wrap", cnt_o, 3);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R2 flag cleared", ovf_o, 0);
    inst_tick_i = 1'b0; cyc(3);
    chk("R1 no tick no step", cnt_o, 4);
    for (int i = 0; i < 4; i++) begin
      inst_tick_i = 1'b1; cyc(1);
      inst_tick_i = 1'b0; cyc(1);
    end
    chk("R1 gapped ticks", cnt_o, 8);
    inst_tick_i = 1'b1;
    load(254); cyc(3); chk("R1 reach max", cnt_o, 255);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R2 set beats clear", ovf_o, 1);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
  endtask

  task automatic t_write_priority;
    ctrl_i = 6'b001000; inst_tick_i = 1'b1;
    load(252); cyc(5); chk("R4 at max", cnt_o, 255);
    wr_en_i = 1'b1; wr_data_i = 8'h10; cyc(1); wr_en_i = 1'b0;
    chk("R4 write wins", cnt_o, 16);
    chk("R4 no flag", ovf_o, 0);
    cyc(2); chk("R3 frozen after load", cnt_o, 16);
    cyc(1); chk("R3 resumes", cnt_o, 17);
  endtask

  task automatic t_ext_source;
    ctrl_i = 6'b101000; inst_tick_i = 1'b1; ext_clk_i = 1'b0;
    load(0); cyc(6); chk("R5 inst ignored", cnt_o, 0);
    ext_clk_i = 1'b1; cyc(2); chk("R6 sync delay", cnt_o, 0);
    cyc(1); chk("R6 rising counted", cnt_o, 1);
    cyc(3); chk("R6 single count", cnt_o, 1);
    ext_clk_i = 1'b0; cyc(4); chk("R6 falling ignored", cnt_o, 1);
    ctrl_i = 6'b111000; cyc(2);
    ext_clk_i = 1'b1; cyc(4); chk("R6 rising ignored", cnt_o, 1);
    ext_clk_i = 1'b0; cyc(2); chk("R6 fall delay", cnt_o, 1);
    cyc(1); chk("R6 falling counted", cnt_o, 2);
  endtask

  task automatic t_prescale;
    inst_tick_i = 1'b1;
    ctrl_i = 6'b000001;
    load(0); cyc(3); chk("R7 ratio4 before", cnt_o, 0);
    cyc(1); chk("R7 ratio4 first", cnt_o, 1);
    cyc(3); chk("R7 ratio4 hold", cnt_o, 1);
    cyc(1); chk("R7 ratio4 second", cnt_o, 2);
    ctrl_i = 6'b000111;
    load(0); cyc(255); chk("R7 ratio256 before", cnt_o, 0);
    cyc(1); chk("R7 ratio256 step", cnt_o, 1);
    ctrl_i = 6'b000001;
    load(0); cyc(2);
    load(5); cyc(3); chk("R9 write clears psc", cnt_o, 5);
    cyc(1); chk("R9 full period after write", cnt_o, 6);
    load(0); cyc(2);
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    cyc(1); chk("R9 wdt_clr ignored for timer", cnt_o, 1);
  endtask

  task automatic wdt_pulses(int n, int hit, string req);
    for (int k = 1; k <= n; k++) begin
      wdt_osc_i = 1'b1; #1;
      chk(req, wdt_tick_o, (k == hit) ? 1 : 0);
      cyc(1);
      wdt_osc_i = 1'b0; cyc(1);
    end
  endtask

  task automatic t_wdt_share;
    inst_tick_i = 1'b0;
    ctrl_i = 6'b001010;
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    wdt_pulses(8, 8, "R8 wdt divided by 8");
    wdt_pulses(3, 0, "R8 partial period");
    wdt_clr_i = 1'b1; cyc(1); wdt_clr_i = 1'b0;
    wdt_pulses(8, 8, "R9 wdt_clr restarts psc");
    ctrl_i = 6'b000010;
    wdt_osc_i = 1'b1; #1; chk("R8 passthrough high", wdt_tick_o, 1);
    cyc(1);
    wdt_osc_i = 1'b0; #1; chk("R8 passthrough low", wdt_tick_o, 0);
    cyc(1);
  endtask

  task automatic t_sleep;
    ctrl_i = 6'b001000; inst_tick_i = 1'b1;
    load(40); cyc(2);
    sleep_i = 1'b1; cyc(6); chk("R10 frozen in sleep", cnt_o, 40);
    sleep_i = 1'b0; cyc(1); chk("R10 resumes", cnt_o, 41);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_wrap_flag();
    t_write_priority();
    t_ext_source();
    t_prescale();
    t_wdt_share();
    t_sleep();
    summary();
    $finish;
  end
endmodule